// File: doc/BRIEF.md
# ISO14443A Wake-up Short Frame Detector

This block sits behind the demodulator of a type A card emulator. It watches the reader-to-card pause signal and picks out the two wake-up short frames. Every clock carries one sample of the pause line. The bit cell is four samples long, or two samples long when the ratio input is high. The detector waits for a falling edge of the carrier and tests the first cell for the start-of-frame shape. When the shape matches, it collects the next eight cells into one 32-bit capture word. It then takes one more cell, which has to be idle. In a single step it decodes the word with Modified Miller rules and sorts the frame into REQA, WUPA or neither.

The outcome is offered on a valid/ready result port. The port carries a two-bit code and the value of the last data bit, which the response-delay logic uses to place its answer. A result stays on the port until it is taken. While it waits, pause edges on the line are ignored, so a frame that arrives during that time is dropped. In the cycle the result is taken the detector is armed again. A pause edge in that same cycle therefore starts a new frame.

Top module: `wakeup_frame_det`

## Requirements
- R1: While reset is active, and right after it is released, `res_valid` is 0 and `res_code` is 0.
- R2: A REQA frame (7-bit value 0x26, sent LSB first with no parity) gives code 2'b01 with `res_last` = 0. In 4x mode `res_valid` rises on the clock edge that takes in the 40th sample, counting from the first pause sample as sample 1.
- R3: A WUPA frame (7-bit value 0x52, sent LSB first) gives code 2'b10 with `res_last` = 1.
- R4: With `ratio_2x` = 1 a cell is two samples: sample 0 is the first half and sample 1 is the second half. With `ratio_2x` = 0 a cell is four samples: samples 0 and 1 are the first half, samples 2 and 3 the second half. The ratio is latched at the first pause sample, and a change during the frame has no effect.
- R5: The first cell is accepted as a start of frame only when the pause is in sample 0 alone. Any other first cell produces no result, and the detector goes back to waiting for an edge.
- R6: A frame that is well formed but carries another 7-bit value gives code 2'b00 with `res_last` = 0. Code 2'b11 never appears.
- R7: Cells decode as follows. A pause in the second half is 1. A pause in the first half is 0. No pause is 0 when it follows a 1. The frame is rejected with code 2'b00 in any of these cases: a pause in both halves, a first-half pause after a 1, no pause after a 0 inside the eight cells, an eighth cell that is not 0, or a ninth cell that is not idle.
- R8: While `res_valid` is 1 and `res_ready` is 0, valid, code and last bit hold steady and pause edges start nothing. The result is consumed in a cycle where both are 1.
- R9: A pause edge in the same cycle as a result hand-over starts a new frame.
- R10: A pause edge needs the previous sample to be idle. A line that is paused through reset starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pause | input | 1 | 1 while the carrier pause is seen |
| ratio_2x | input | 1 | 1: two samples per bit cell, 0: four |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_code | output | 2 | 00 none, 01 REQA, 10 WUPA |
| res_last | output | 1 | Last data bit of an accepted frame |

## Verification
Two events can fall in the same clock cycle: the hand-over of a pending result and the first pause sample of the next frame. The bench provokes this by holding `res_ready` low after a REQA. It then raises `res_ready` in the exact sample where a following WUPA begins. The scoreboard must receive the REQA and then the WUPA, in that order, with nothing lost or extra. A second run keeps `res_ready` low across a whole frame, and that frame must leave no trace.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_REQA = 2'b01,
    RES_WUPA = 2'b10
  } res_code_e;

  typedef enum logic [2:0] {
    ST_HUNT = 3'd0,
    ST_SOF  = 3'd1,
    ST_CAPT = 3'd2,
    ST_TAIL = 3'd3,
    ST_RES  = 3'd4
  } det_state_e;

endpackage

// File: rtl/sfd_cell_framer.sv
// Gathers the samples of one bit cell into a slot vector.
// Four-sample mode fills one slot per sample; two-sample mode fills half the slots per sample.
module sfd_cell_framer #(
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             x2,
  input  logic             smp,
  output logic             done,
  output logic [SLOTS-1:0] nib
);
  localparam int CW   = $clog2(SLOTS);
  localparam int HALF = SLOTS / 2;

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    pos;
  logic [CW-1:0]    last_idx;
  logic [SLOTS-1:0] acc_q;
  logic [SLOTS-1:0] fill;

  assign pos      = start ? '0 : cnt_q;
  assign last_idx = x2 ? CW'(1) : CW'(SLOTS - 1);

  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      if (x2) fill[j] = smp && ((j / HALF) == int'(pos));
      else    fill[j] = smp && (j == int'(pos));
    end
  end

  assign done = run && (cnt_q == last_idx);
  assign nib  = acc_q | fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (start) begin
      acc_q <= fill;
      cnt_q <= CW'(1);
    end else if (run) begin
      if (done) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_q | fill;
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last_idx));

  // R9
  start_run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && run));

endmodule

// File: rtl/sfd_capture.sv
// Shifts finished cells into the capture word; the first cell ends up in the lowest slots.
module sfd_capture #(
  parameter int CELLS = 8,
  parameter int SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   shift,
  input  logic [SLOTS-1:0]       nib,
  output logic [CELLS*SLOTS-1:0] word,
  output logic                   last_cell
);
  localparam int W  = CELLS * SLOTS;
  localparam int NW = $clog2(CELLS + 1);

  logic [W-1:0]  word_q;
  logic [NW-1:0] n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      n_q    <= '0;
    end else if (clr) begin
      word_q <= '0;
      n_q    <= '0;
    end else if (shift) begin
      word_q <= {nib, word_q[W-1:SLOTS]};
      n_q    <= n_q + NW'(1);
    end
  end

  assign word      = word_q;
  assign last_cell = (n_q == NW'(CELLS - 1));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= NW'(CELLS));

endmodule

// File: rtl/sfd_decoder.sv
// Combinational Modified Miller decode and classification of a captured short frame.
module sfd_decoder
  import sfd_pkg::*;
#(
  parameter int                   CELLS     = 8,
  parameter int                   SLOTS     = 4,
  parameter int                   DATA_BITS = 7,
  parameter logic [DATA_BITS-1:0] REQA_VAL  = 7'h26,
  parameter logic [DATA_BITS-1:0] WUPA_VAL  = 7'h52
) (
  input  logic [CELLS*SLOTS-1:0] word,
  input  logic [SLOTS-1:0]       tail,
  output logic [1:0]             code,
  output logic                   last
);
  localparam int HALF = SLOTS / 2;

  logic [CELLS-1:0]     bits;
  logic [DATA_BITS-1:0] data;
  logic                 bad;

  always_comb begin
    logic f;
    logic s;
    logic b;
    logic prv;
    prv  = 1'b0;
    bad  = 1'b0;
    bits = '0;
    for (int i = 0; i < CELLS; i++) begin
      f = |word[i*SLOTS +: HALF];
      s = |word[i*SLOTS+HALF +: SLOTS-HALF];
      b = 1'b0;
      if (f && s) begin
        bad = 1'b1;
      end else if (s) begin
        b = 1'b1;
      end else if (f) begin
        if (prv) bad = 1'b1;
      end else begin
        if (!prv) bad = 1'b1;
      end
      bits[i] = b;
      prv     = b;
    end
    if (bits[CELLS-1] || (|tail)) bad = 1'b1;
    data = bits[DATA_BITS-1:0];
    code = RES_NONE;
    last = 1'b0;
    if (!bad && data == REQA_VAL) begin
      code = RES_REQA;
      last = data[DATA_BITS-1];
    end else if (!bad && data == WUPA_VAL) begin
      code = RES_WUPA;
      last = data[DATA_BITS-1];
    end
  end

endmodule

// File: rtl/wakeup_frame_det.sv
module wakeup_frame_det
  import sfd_pkg::*;
#(
  parameter int                   SLOTS     = 4,
  parameter int                   DATA_BITS = 7,
  parameter logic [DATA_BITS-1:0] REQA_VAL  = 7'h26,
  parameter logic [DATA_BITS-1:0] WUPA_VAL  = 7'h52
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_pause,
  input  logic       ratio_2x,
  output logic       res_valid,
  input  logic       res_ready,
  output logic [1:0] res_code,
  output logic       res_last
);
  localparam int CELLS = DATA_BITS + 1;
  localparam int W     = CELLS * SLOTS;
  localparam int HALF  = SLOTS / 2;

  det_state_e st_q, st_d;
  logic       prev_q;
  logic       mode_q;
  logic       edge_seen, hunt_ok, start, run, done, sof_ok;
  logic       x2_now;
  logic [SLOTS-1:0] nib, sof_pat;
  logic [W-1:0]     word;
  logic             cap_last;
  logic [1:0]       dec_code;
  logic             dec_last;
  logic [1:0]       code_q;
  logic             last_q;

  assign edge_seen = rx_pause && !prev_q;
  assign hunt_ok   = (st_q == ST_HUNT) || (st_q == ST_RES && res_ready);
  assign start     = hunt_ok && edge_seen;
  assign run       = (st_q == ST_SOF) || (st_q == ST_CAPT) || (st_q == ST_TAIL);
  assign x2_now    = start ? ratio_2x : mode_q;

  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      sof_pat[j] = mode_q ? (j < HALF) : (j == 0);
    end
  end
  assign sof_ok = (nib == sof_pat);

  sfd_cell_framer #(.SLOTS(SLOTS)) u_framer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .run   (run),
    .x2    (x2_now),
    .smp   (rx_pause),
    .done  (done),
    .nib   (nib)
  );

  sfd_capture #(.CELLS(CELLS), .SLOTS(SLOTS)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start),
    .shift     (st_q == ST_CAPT && done),
    .nib       (nib),
    .word      (word),
    .last_cell (cap_last)
  );

  sfd_decoder #(
    .CELLS     (CELLS),
    .SLOTS     (SLOTS),
    .DATA_BITS (DATA_BITS),
    .REQA_VAL  (REQA_VAL),
    .WUPA_VAL  (WUPA_VAL)
  ) u_decoder (
    .word (word),
    .tail (nib),
    .code (dec_code),
    .last (dec_last)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_HUNT: if (start) st_d = ST_SOF;
      ST_SOF:  if (done) st_d = sof_ok ? ST_CAPT : ST_HUNT;
      ST_CAPT: if (done && cap_last) st_d = ST_TAIL;
      ST_TAIL: if (done) st_d = ST_RES;
      ST_RES:  if (res_ready) st_d = start ? ST_SOF : ST_HUNT;
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      prev_q <= 1'b1;
      mode_q <= 1'b0;
      code_q <= RES_NONE;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      prev_q <= rx_pause;
      if (start) mode_q <= ratio_2x;
      if (st_q == ST_TAIL && done) begin
        code_q <= dec_code;
        last_q <= dec_last;
      end
    end
  end

  assign res_valid = (st_q == ST_RES);
  assign res_code  = code_q;
  assign res_last  = last_q;

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) && $stable(res_last)));

  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_code != 2'b11));

  // R2
  reqa_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == RES_REQA) |-> !res_last);

  // R3
  wupa_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == RES_WUPA) |-> res_last);

  // R9
  rearm_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && rx_pause && !prev_q) |=> (st_q == ST_SOF));

  // R10
  held_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HUNT && rx_pause && prev_q) |=> (st_q == ST_HUNT));

endmodule

// File: tb/wakeup_frame_det_test.sv
module wakeup_frame_det_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] SY_Y = 2'd0, SY_X = 2'd1, SY_Z = 2'd2, SY_B = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n, rx_pause, ratio_2x, res_ready;
  logic       res_valid, res_last;
  logic [1:0] res_code;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wakeup_frame_det uut (
    .clk(clk), .rst_n(rst_n), .rx_pause(rx_pause), .ratio_2x(ratio_2x),
    .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code), .res_last(res_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_pause = 1'b0;
    end
  endtask

  task automatic drive_cell(input logic [1:0] sym, input logic x2);
    logic a, b;
    a = (sym == SY_Z) || (sym == SY_B);
    b = (sym == SY_X) || (sym == SY_B);
    if (x2) begin
      @(negedge clk); rx_pause = a;
      @(negedge clk); rx_pause = b;
    end else begin
      @(negedge clk); rx_pause = a;
      @(negedge clk); rx_pause = 1'b0;
      @(negedge clk); rx_pause = b;
      @(negedge clk); rx_pause = 1'b0;
    end
  endtask

  function automatic logic [17:0] encode(input logic [6:0] d);
    logic [17:0] sy;
    logic prv;
    prv = 1'b0;
    for (int i = 0; i < 7; i++) begin
      sy[2*i +: 2] = d[i] ? SY_X : (prv ? SY_Y : SY_Z);
      prv = d[i];
    end
    sy[15:14] = prv ? SY_Y : SY_Z;
    sy[17:16] = SY_Y;
    return sy;
  endfunction

  task automatic send_syms(input logic [17:0] sy, input logic x2, input logic flip, input logic rel);
    @(negedge clk);
    rx_pause = 1'b1;
    ratio_2x = x2;
    if (rel) res_ready = 1'b1;
    if (x2) begin
      @(negedge clk); rx_pause = 1'b0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); rx_pause = 1'b0;
      end
    end
    if (flip) ratio_2x = ~x2;
    for (int i = 0; i < 9; i++) drive_cell(sy[2*i +: 2], x2);
  endtask

  task automatic push(input logic [1:0] code, input logic last, input string tag);
    exp_q.push_back({last, code});
    tag_q.push_back(tag);
  endtask

  task automatic frame(input logic [6:0] d, input logic x2, input logic flip, input logic rel,
                       input bit expect_it, input string tag);
    logic [1:0] c;
    c = (d == 7'h26) ? 2'b01 : ((d == 7'h52) ? 2'b10 : 2'b00);
    if (expect_it) push(c, (c != 2'b00) ? d[6] : 1'b0, tag);
    send_syms(encode(d), x2, flip, rel);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n === 1'b1 && res_valid === 1'b1 && res_ready === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", {29'd0, res_last, res_code}, 32'd0);
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({res_last, res_code} === e, t, {29'd0, res_last, res_code}, {29'd0, e});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [17:0] sy;
    rst_n = 1'b0; rx_pause = 1'b1; ratio_2x = 1'b0; res_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(res_valid == 1'b0, "R1 valid in reset", {31'd0, res_valid}, 32'd0);
    chk(res_code == 2'b00, "R1 code in reset", {30'd0, res_code}, 32'd0);
    // R10: the line stays paused across the release of reset
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); rx_pause = 1'b0;
    #1;
    chk(res_valid == 1'b0, "R1 valid after reset", {31'd0, res_valid}, 32'd0);
    idle(60);
    chk(res_valid == 1'b0, "R10 held pause", {31'd0, res_valid}, 32'd0);

    // R2 REQA in 4x mode, with exact timing
    frame(7'h26, 1'b0, 1'b0, 1'b0, 1'b1, "R2 REQA 4x");
    #1;
    chk(res_valid == 1'b0, "R2 early valid", {31'd0, res_valid}, 32'd0);
    @(negedge clk); #1;
    chk(res_valid == 1'b1, "R2 valid timing", {31'd0, res_valid}, 32'd1);
    idle(4);

    // R3 WUPA in 4x mode
    frame(7'h52, 1'b0, 1'b0, 1'b0, 1'b1, "R3 WUPA 4x");
    idle(4);

    // R4 two-sample cells, and a ratio change during the frame
    frame(7'h26, 1'b1, 1'b0, 1'b0, 1'b1, "R4 REQA 2x");
    idle(4);
    frame(7'h52, 1'b1, 1'b0, 1'b0, 1'b1, "R4 WUPA 2x");
    idle(4);
    frame(7'h52, 1'b1, 1'b1, 1'b0, 1'b1, "R4 WUPA 2x ratio flip");
    idle(4);
    frame(7'h26, 1'b0, 1'b1, 1'b0, 1'b1, "R4 REQA 4x ratio flip");
    idle(4);

    // R6 well-formed frames carrying other values
    frame(7'h35, 1'b0, 1'b0, 1'b0, 1'b1, "R6 value 0x35");
    idle(4);
    frame(7'h27, 1'b1, 1'b0, 1'b0, 1'b1, "R6 value 0x27 2x");
    idle(4);

    // R7 illegal codings
    sy = encode(7'h26); sy[5:4] = SY_B;
    push(2'b00, 1'b0, "R7 pause in both halves");
    send_syms(sy, 1'b0, 1'b0, 1'b0); idle(4);
    sy = encode(7'h52); sy[5:4] = SY_Z;
    push(2'b00, 1'b0, "R7 first-half pause after 1");
    send_syms(sy, 1'b0, 1'b0, 1'b0); idle(4);
    sy = encode(7'h26); sy[1:0] = SY_Y;
    push(2'b00, 1'b0, "R7 idle cell after 0");
    send_syms(sy, 1'b1, 1'b0, 1'b0); idle(4);
    sy = encode(7'h26); sy[17:16] = SY_X;
    push(2'b00, 1'b0, "R7 tail not idle");
    send_syms(sy, 1'b0, 1'b0, 1'b0); idle(4);

    // R5 malformed start cells
    @(negedge clk); rx_pause = 1'b1; ratio_2x = 1'b0;
    @(negedge clk); rx_pause = 1'b1;
    idle(50);
    chk(res_valid == 1'b0, "R5 long pause start 4x", {31'd0, res_valid}, 32'd0);
    @(negedge clk); rx_pause = 1'b1; ratio_2x = 1'b1;
    @(negedge clk); rx_pause = 1'b1;
    idle(50);
    chk(res_valid == 1'b0, "R5 long pause start 2x", {31'd0, res_valid}, 32'd0);

    // R8 back-pressure: the result holds and a frame during the wait is dropped
    @(negedge clk); res_ready = 1'b0;
    frame(7'h26, 1'b0, 1'b0, 1'b0, 1'b1, "R8 held REQA");
    idle(5);
    #1;
    chk(res_valid == 1'b1, "R8 valid held", {31'd0, res_valid}, 32'd1);
    chk(res_code == 2'b01, "R8 code held", {30'd0, res_code}, 32'd1);
    frame(7'h52, 1'b0, 1'b0, 1'b0, 1'b0, "R8 dropped");
    #1;
    chk(res_code == 2'b01 && res_valid == 1'b1, "R8 still REQA after ignored frame",
        {29'd0, res_valid, res_code}, 32'd5);
    idle(2);
    @(negedge clk); res_ready = 1'b1;
    idle(60);

    // R9 hand-over and start of frame in the same cycle
    @(negedge clk); res_ready = 1'b0;
    frame(7'h26, 1'b0, 1'b0, 1'b0, 1'b1, "R9 first REQA");
    idle(3);
    frame(7'h52, 1'b0, 1'b0, 1'b1, 1'b1, "R9 WUPA started at hand-over");
    idle(50);

    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 32'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule